// File: doc/BRIEF.md
# Accumulator Instruction Processor

This block is a small multi-cycle processor for a word-oriented teaching architecture. Every arithmetic result lands in one 24-bit accumulator, which works against an operand word in memory. An index register forms indexed addresses and drives counted loops. A linkage register holds subroutine return addresses. A two-bit condition code is written only by compare-style instructions and is read by the conditional branches. The core fetches and executes one instruction at a time over a byte-wide synchronous memory port. It talks to peripherals through a byte-wide device port with a ready input and single-cycle read and write strobes.

Each instruction is three bytes long. A fetch takes four cycles, because the memory returns each byte one cycle after it is requested. Execution then takes one more cycle. A memory operand adds four cycles for a word read, three for a word write, two for a byte read, or one for a byte write. Jumps, calls, returns and device operations finish in the execute cycle. When an opcode that is not defined is fetched, the core raises `halt` and stays quiet until the next reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held and until the first fetch begins, `mem_rd`, `mem_wr`, `dev_rd`, `dev_wr` and `halt` are all 0. The first byte read after reset is at address 0.
- R2: An instruction is three bytes, fetched in big-endian order. Bits 23:16 are the opcode, bit 15 is the index flag and bits 14:0 are the address field. When the index flag is 1, the target address is the address field plus the low 15 bits of the index register, modulo 32768. Opcodes in hex: 10 load A, 14 load X, 18 load L, 1C store A, 20 store X, 24 store L, 28 byte load, 2C byte store, 30 add, 34 subtract, 38 compare, 40 branch if less, 44 branch if equal, 48 branch if greater, 4C jump, 50 call, 54 return, 58 step index, 60 device test, 64 device input, 68 device output.
- R3: Word loads and stores move three bytes, with the lowest address holding bits 23:16. A byte load replaces only bits 7:0 of A. A byte store writes bits 7:0 of A to one byte.
- R4: Add and subtract combine A with the memory word, leave the result in A and wrap modulo 2^24.
- R5: Compare checks A against the memory word as signed 24-bit values and records less, equal or greater. Each conditional branch is taken only when the recorded result matches. Jump is always taken.
- R6: Call stores the address of the following instruction, zero-extended, in L and jumps to the target. Return jumps to the address held in L.
- R7: Step index adds one to X and then compares the new X with the memory word as a signed value, recording less, equal or greater.
- R8: A device operation addresses device `dev_id` = target address bits 7:0. Device test records less when `dev_ready` is 1 and equal when it is 0. Device input pulses `dev_rd` for one cycle and replaces bits 7:0 of A with `dev_rdata`. Device output pulses `dev_wr` for one cycle with `dev_wdata` = A bits 7:0.
- R9: Fetching an undefined opcode sets `halt`. Halt holds until reset, and the core makes no further memory or device access.
- R10: The memory port moves one byte per cycle, with read data valid on the cycle after `mem_rd`. `mem_rd` and `mem_wr` are never both high, and a word access takes three byte cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_addr | output | 15 | Byte address for memory |
| mem_rd | output | 1 | Memory byte read request |
| mem_wr | output | 1 | Memory byte write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid the cycle after the request |
| dev_id | output | 8 | Device number for device operations |
| dev_ready | input | 1 | Addressed device is ready |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | 8 | Byte sent to the device |
| dev_rdata | input | 8 | Byte returned by the device |
| halt | output | 1 | Core stopped on an undefined opcode |

## Verification
The arithmetic and compare paths run from a table of operand pairs. The add and subtract pairs include positive overflow, negative wrap and borrow through zero, which separate correct modular wrap from saturation or a carry dropped at the wrong width. The compare pairs straddle the sign bit, so a signed result is told apart from an unsigned one, and they take each of the three branch paths in turn. A directed program then runs an indexed byte-copy loop closed by step index, a call and return, a byte load that must keep the upper accumulator bits, and a device poll whose ready input comes late. This distinguishes the ready and busy encodings, the off-by-one in the loop bound, and the return address value.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OPC_LD_A   = 8'h10;
  localparam logic [OPC_W-1:0] OPC_LD_X   = 8'h14;
  localparam logic [OPC_W-1:0] OPC_LD_L   = 8'h18;
  localparam logic [OPC_W-1:0] OPC_ST_A   = 8'h1C;
  localparam logic [OPC_W-1:0] OPC_ST_X   = 8'h20;
  localparam logic [OPC_W-1:0] OPC_ST_L   = 8'h24;
  localparam logic [OPC_W-1:0] OPC_LD_B   = 8'h28;
  localparam logic [OPC_W-1:0] OPC_ST_B   = 8'h2C;
  localparam logic [OPC_W-1:0] OPC_ADD    = 8'h30;
  localparam logic [OPC_W-1:0] OPC_SUB    = 8'h34;
  localparam logic [OPC_W-1:0] OPC_CMP    = 8'h38;
  localparam logic [OPC_W-1:0] OPC_BR_LT  = 8'h40;
  localparam logic [OPC_W-1:0] OPC_BR_EQ  = 8'h44;
  localparam logic [OPC_W-1:0] OPC_BR_GT  = 8'h48;
  localparam logic [OPC_W-1:0] OPC_JMP    = 8'h4C;
  localparam logic [OPC_W-1:0] OPC_CALL   = 8'h50;
  localparam logic [OPC_W-1:0] OPC_RET    = 8'h54;
  localparam logic [OPC_W-1:0] OPC_STEPX  = 8'h58;
  localparam logic [OPC_W-1:0] OPC_DEV_T  = 8'h60;
  localparam logic [OPC_W-1:0] OPC_DEV_I  = 8'h64;
  localparam logic [OPC_W-1:0] OPC_DEV_O  = 8'h68;

  typedef enum logic [3:0] {
    CL_LDW, CL_STW, CL_LDB, CL_STB, CL_ALU, CL_CMP, CL_STEP,
    CL_JMP, CL_CALL, CL_RET, CL_TST, CL_DIN, CL_DOUT, CL_BAD
  } cls_e;

  typedef enum logic [1:0] {RS_A, RS_X, RS_L} rsel_e;
  typedef enum logic [1:0] {JC_ALWAYS, JC_LT, JC_EQ, JC_GT} jc_e;
  typedef enum logic [1:0] {CC_NONE, CC_LT, CC_EQ, CC_GT} cc_e;
  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_RDW, ST_WRW, ST_HALT} st_e;

  typedef struct packed {
    cls_e  cls;
    rsel_e rsel;
    logic  sub;
    jc_e   jc;
    logic  byte_op;
  } dec_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output dec_t             dec
);

  always_comb begin
    dec = '{cls: CL_BAD, rsel: RS_A, sub: 1'b0, jc: JC_ALWAYS, byte_op: 1'b0};
    case (opcode)
      OPC_LD_A:  dec.cls = CL_LDW;
      OPC_LD_X:  begin dec.cls = CL_LDW; dec.rsel = RS_X; end
      OPC_LD_L:  begin dec.cls = CL_LDW; dec.rsel = RS_L; end
      OPC_ST_A:  dec.cls = CL_STW;
      OPC_ST_X:  begin dec.cls = CL_STW; dec.rsel = RS_X; end
      OPC_ST_L:  begin dec.cls = CL_STW; dec.rsel = RS_L; end
      OPC_LD_B:  begin dec.cls = CL_LDB; dec.byte_op = 1'b1; end
      OPC_ST_B:  begin dec.cls = CL_STB; dec.byte_op = 1'b1; end
      OPC_ADD:   dec.cls = CL_ALU;
      OPC_SUB:   begin dec.cls = CL_ALU; dec.sub = 1'b1; end
      OPC_CMP:   dec.cls = CL_CMP;
      OPC_BR_LT: begin dec.cls = CL_JMP; dec.jc = JC_LT; end
      OPC_BR_EQ: begin dec.cls = CL_JMP; dec.jc = JC_EQ; end
      OPC_BR_GT: begin dec.cls = CL_JMP; dec.jc = JC_GT; end
      OPC_JMP:   dec.cls = CL_JMP;
      OPC_CALL:  dec.cls = CL_CALL;
      OPC_RET:   dec.cls = CL_RET;
      OPC_STEPX: dec.cls = CL_STEP;
      OPC_DEV_T: dec.cls = CL_TST;
      OPC_DEV_I: dec.cls = CL_DIN;
      OPC_DEV_O: dec.cls = CL_DOUT;
      default:   dec.cls = CL_BAD;
    endcase
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int WORD_W = 24
)(
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic              sub,
  output logic [WORD_W-1:0] res,
  output cc_e               rel
);

  always_comb begin
    res = sub ? (opa - opb) : (opa + opb);
    if ($signed(opa) < $signed(opb))
      rel = CC_LT;
    else if (opa == opb)
      rel = CC_EQ;
    else
      rel = CC_GT;
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int WORD_W   = 24,
  parameter int BYTE_W   = 8,
  parameter int DEV_W    = 8,
  parameter int RESET_PC = 0
)(
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [DEV_W-1:0]  dev_id,
  input  logic              dev_ready,
  output logic              dev_rd,
  output logic              dev_wr,
  output logic [BYTE_W-1:0] dev_wdata,
  input  logic [BYTE_W-1:0] dev_rdata,
  output logic              halt
);

  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES + 1);
  localparam int MD_W   = WORD_W - BYTE_W;

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // architectural and control state
  st_e              state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [WORD_W-1:0] a_q, a_d, x_q, x_d, l_q, l_d;
  cc_e              cc_q, cc_d;
  // datapath holding registers, no reset
  logic [WORD_W-1:0] ir_q, ir_d;
  logic              ir_en;
  logic [MD_W-1:0]   md_q, md_d;
  logic              md_en;
  logic [ADDR_W-1:0] ta_q, ta_d;
  logic              ta_en;

  dec_t              dec;
  logic [ADDR_W-1:0] ta_calc;
  logic [WORD_W-1:0] word_in, src_word, alu_a, alu_res;
  logic [BYTE_W-1:0] wr_byte;
  cc_e               alu_rel;
  logic [CNT_W-1:0]  last_idx, done_idx;
  logic              take;

  acc_cpu_decode u_dec (
    .opcode (ir_q[WORD_W-1 -: OPC_W]),
    .dec    (dec)
  );

  acc_cpu_alu #(.WORD_W(WORD_W)) u_alu (
    .opa (alu_a),
    .opb (word_in),
    .sub (dec.sub),
    .res (alu_res),
    .rel (alu_rel)
  );

  assign ta_calc  = ir_q[ADDR_W-1:0] + (ir_q[ADDR_W] ? x_q[ADDR_W-1:0] : '0);
  assign word_in  = {md_q, mem_rdata};
  assign alu_a    = (dec.cls == CL_STEP) ? x_q : a_q;
  assign last_idx = dec.byte_op ? '0 : CNT_W'(NBYTES - 1);
  assign done_idx = last_idx + 1'b1;

  always_comb begin
    case (dec.rsel)
      RS_X:    src_word = x_q;
      RS_L:    src_word = l_q;
      default: src_word = a_q;
    endcase
    wr_byte = '0;
    for (int i = 0; i < NBYTES; i++)
      if (cnt_q == CNT_W'(i)) wr_byte = src_word[(NBYTES-1-i)*BYTE_W +: BYTE_W];
    case (dec.jc)
      JC_LT:   take = (cc_q == CC_LT);
      JC_EQ:   take = (cc_q == CC_EQ);
      JC_GT:   take = (cc_q == CC_GT);
      default: take = 1'b1;
    endcase
  end

  // next-state and output logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    pc_d      = pc_q;
    a_d       = a_q;
    x_d       = x_q;
    l_d       = l_q;
    cc_d      = cc_q;
    ir_en     = 1'b0;
    ir_d      = {ir_q[WORD_W-BYTE_W-1:0], mem_rdata};
    md_en     = 1'b0;
    md_d      = word_in[MD_W-1:0];
    ta_en     = 1'b0;
    ta_d      = ta_calc;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = pc_q;
    mem_wdata = '0;
    dev_rd    = 1'b0;
    dev_wr    = 1'b0;
    dev_id    = ta_calc[DEV_W-1:0];
    dev_wdata = a_q[BYTE_W-1:0];

    case (state_q)
      ST_IDLE: state_d = ST_FETCH;

      ST_FETCH: begin
        if (cnt_q < CNT_W'(NBYTES)) begin
          mem_rd   = 1'b1;
          mem_addr = pc_q + ADDR_W'(cnt_q);
        end
        if (cnt_q != '0) ir_en = 1'b1;
        if (cnt_q == CNT_W'(NBYTES)) begin
          state_d = ST_EXEC;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      ST_EXEC: begin
        ta_en   = 1'b1;
        cnt_d   = '0;
        pc_d    = pc_q + ADDR_W'(NBYTES);
        state_d = ST_FETCH;
        case (dec.cls)
          CL_LDW, CL_LDB, CL_ALU, CL_CMP: state_d = ST_RDW;
          CL_STEP: begin
            x_d     = x_q + 1'b1;
            state_d = ST_RDW;
          end
          CL_STW, CL_STB: state_d = ST_WRW;
          CL_JMP: if (take) pc_d = ta_calc;
          CL_CALL: begin
            l_d  = WORD_W'(pc_q + ADDR_W'(NBYTES));
            pc_d = ta_calc;
          end
          CL_RET: pc_d = l_q[ADDR_W-1:0];
          CL_TST: cc_d = dev_ready ? CC_LT : CC_EQ;
          CL_DIN: begin
            dev_rd              = 1'b1;
            a_d[BYTE_W-1:0]     = dev_rdata;
          end
          CL_DOUT: dev_wr = 1'b1;
          default: begin
            pc_d    = pc_q;
            state_d = ST_HALT;
          end
        endcase
      end

      ST_RDW: begin
        if (cnt_q <= last_idx) begin
          mem_rd   = 1'b1;
          mem_addr = ta_q + ADDR_W'(cnt_q);
        end
        if (cnt_q != '0) md_en = 1'b1;
        if (cnt_q == done_idx) begin
          state_d = ST_FETCH;
          cnt_d   = '0;
          case (dec.cls)
            CL_LDW: begin
              case (dec.rsel)
                RS_X:    x_d = word_in;
                RS_L:    l_d = word_in;
                default: a_d = word_in;
              endcase
            end
            CL_LDB:  a_d[BYTE_W-1:0] = mem_rdata;
            CL_ALU:  a_d = alu_res;
            default: cc_d = alu_rel;
          endcase
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      ST_WRW: begin
        mem_wr    = 1'b1;
        mem_addr  = ta_q + ADDR_W'(cnt_q);
        mem_wdata = dec.byte_op ? a_q[BYTE_W-1:0] : wr_byte;
        if (cnt_q == last_idx) begin
          state_d = ST_FETCH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pc_q    <= ADDR_W'(RESET_PC);
      a_q     <= '0;
      x_q     <= '0;
      l_q     <= '0;
      cc_q    <= CC_NONE;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pc_q    <= pc_d;
      a_q     <= a_d;
      x_q     <= x_d;
      l_q     <= l_d;
      cc_q    <= cc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ir_en) ir_q <= ir_d;
    if (md_en) md_q <= md_d;
    if (ta_en) ta_q <= ta_d;
  end

  assign halt = (state_q == ST_HALT);

endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_rd,
  input logic mem_wr,
  input logic dev_rd,
  input logic dev_wr,
  input logic halt
);

  a_r10_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rd && dev_wr));

  a_r8_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd |=> !dev_rd);

  a_r8_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |=> !dev_wr);

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!mem_rd && !mem_wr && !dev_rd && !dev_wr));

endmodule

bind acc_cpu_core acc_cpu_core_chk chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .dev_rd (dev_rd),
  .dev_wr (dev_wr),
  .halt   (halt)
);

// File: tb/acc_cpu_core_tb_top.sv
module acc_cpu_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_SZ     = 4096;
  localparam int NVEC       = 9;

  // opcodes as listed in R2
  localparam logic [7:0] O_LDA = 8'h10, O_LDX = 8'h14, O_STA = 8'h1C, O_STX = 8'h20;
  localparam logic [7:0] O_STL = 8'h24, O_LDB = 8'h28, O_STB = 8'h2C, O_ADD = 8'h30;
  localparam logic [7:0] O_SUB = 8'h34, O_CMP = 8'h38, O_BLT = 8'h40, O_BEQ = 8'h44;
  localparam logic [7:0] O_JMP = 8'h4C, O_CALL = 8'h50, O_RET = 8'h54, O_STEP = 8'h58;
  localparam logic [7:0] O_DT = 8'h60, O_DI = 8'h64, O_DO = 8'h68;

  // kind (0 add, 1 sub, 2 compare), operand in A, memory operand, expected result
  localparam logic [73:0] VEC [NVEC] = '{
    {2'd0, 24'h000005, 24'h000007, 24'h00000C},
    {2'd0, 24'h7FFFFF, 24'h000001, 24'h800000},
    {2'd0, 24'hFFFFFF, 24'h000002, 24'h000001},
    {2'd1, 24'h00000A, 24'h000003, 24'h000007},
    {2'd1, 24'h000000, 24'h000001, 24'hFFFFFF},
    {2'd1, 24'h800000, 24'h000001, 24'h7FFFFF},
    {2'd2, 24'hFFFFFF, 24'h000001, 24'h000001},
    {2'd2, 24'h000005, 24'h000005, 24'h000002},
    {2'd2, 24'h7FFFFF, 24'h800000, 24'h000003}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  dev_id;
  logic        dev_ready = 1'b0;
  logic        dev_rd, dev_wr;
  logic [7:0]  dev_wdata;
  logic [7:0]  dev_rdata = 8'hC3;
  logic        halt;

  logic [7:0] mem [0:MEM_SZ-1];
  int rd_cnt = 0, wr_cnt = 0, drd_cnt = 0, dwr_cnt = 0;
  logic [7:0] drd_id = 8'h00, dwr_id = 8'h00, dwr_data = 8'h00;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_id(dev_id), .dev_ready(dev_ready),
    .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .halt(halt)
  );

  // memory model: one byte per cycle, read data one cycle after the request
  always @(posedge clk) begin
    if (mem_rd) begin mem_rdata <= mem[mem_addr[11:0]]; rd_cnt <= rd_cnt + 1; end
    if (mem_wr) begin mem[mem_addr[11:0]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    if (dev_rd) begin drd_cnt <= drd_cnt + 1; drd_id <= dev_id; end
    if (dev_wr) begin dwr_cnt <= dwr_cnt + 1; dwr_id <= dev_id; dwr_data <= dev_wdata; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_SZ; i++) mem[i] <= 8'h00;
  endtask

  task automatic put_word(input int a, input logic [23:0] w);
    mem[a] <= w[23:16]; mem[a+1] <= w[15:8]; mem[a+2] <= w[7:0];
  endtask

  task automatic put_ins(input int a, input logic [7:0] op, input logic xb, input int t);
    put_word(a, {op, xb, 15'(t)});
  endtask

  function automatic logic [23:0] get_word(input int a);
    return {mem[a], mem[a+1], mem[a+2]};
  endfunction

  task automatic do_reset(input bit check_idle);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    if (check_idle) begin
      chk("R1 idle strobes in reset", {mem_rd, mem_wr, dev_rd, dev_wr}, 4'b0000);
      chk("R1 halt low in reset", halt, 1'b0);
    end
    rst_n = 1'b1;
  endtask

  // releases reset, runs until halt; cyc counts cycles from the first fetch
  task automatic run_prog(input int ready_at, output int cyc, output logic [14:0] first_a);
    int n;
    dev_ready = (ready_at == 0);
    do_reset(1'b0);
    n = 0;
    while (!mem_rd && n < 50) begin @(negedge clk); n++; end
    first_a = mem_addr;
    cyc = 0;
    while (!halt && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (cyc == ready_at) dev_ready = 1'b1;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R9: actual=running expected=halted");
    summary();
    $finish;
  end

  initial begin
    int cyc, r0, w0;
    logic [14:0] fa;
    logic [1:0]  kind;
    string       tag;

    do_reset(1'b1);

    // table of arithmetic and compare vectors
    for (int v = 0; v < NVEC; v++) begin
      kind = VEC[v][73:72];
      clear_mem();
      put_ins(0,  O_LDA, 1'b0, 'h200);
      put_ins(3,  (kind == 2'd0) ? O_ADD : (kind == 2'd1) ? O_SUB : O_CMP, 1'b0, 'h203);
      put_ins(6,  (kind == 2'd2) ? O_BLT : O_JMP, 1'b0, (kind == 2'd2) ? 15 : 30);
      put_ins(9,  O_BEQ, 1'b0, 21);
      put_ins(12, O_JMP, 1'b0, 27);
      put_ins(15, O_LDA, 1'b0, 'h209);
      put_ins(18, O_JMP, 1'b0, 30);
      put_ins(21, O_LDA, 1'b0, 'h20C);
      put_ins(24, O_JMP, 1'b0, 30);
      put_ins(27, O_LDA, 1'b0, 'h20F);
      put_ins(30, O_STA, 1'b0, 'h206);
      put_word('h200, VEC[v][71:48]);
      put_word('h203, VEC[v][47:24]);
      put_word('h209, 24'h000001);
      put_word('h20C, 24'h000002);
      put_word('h20F, 24'h000003);
      r0 = rd_cnt; w0 = wr_cnt;
      run_prog(0, cyc, fa);
      @(negedge clk);
      tag = (kind == 2'd0) ? "R4 add wrap" : (kind == 2'd1) ? "R4 sub wrap" : "R5 signed compare branch";
      chk(tag, get_word('h206), VEC[v][23:0]);
      if (v == 0) begin
        chk("R1 first fetch address", fa, 15'h0000);
        chk("R10 cycles to halt", cyc, 36);
        chk("R10 byte reads", rd_cnt - r0, 21);
        chk("R10 byte writes", wr_cnt - w0, 3);
        chk("R9 halt on undefined opcode", halt, 1'b1);
      end
    end

    // directed program: indexed copy loop, call/return, byte load, device I/O
    clear_mem();
    put_ins('h00, O_LDX,  1'b0, 'h300);
    put_ins('h03, O_LDB,  1'b1, 'h320);
    put_ins('h06, O_STB,  1'b1, 'h330);
    put_ins('h09, O_STEP, 1'b0, 'h303);
    put_ins('h0C, O_BLT,  1'b0, 'h003);
    put_ins('h0F, O_STX,  1'b0, 'h306);
    put_ins('h12, O_CALL, 1'b0, 'h060);
    put_ins('h15, O_STA,  1'b0, 'h309);
    put_ins('h18, O_STL,  1'b0, 'h30C);
    put_ins('h1B, O_LDA,  1'b0, 'h30F);
    put_ins('h1E, O_LDB,  1'b0, 'h31B);
    put_ins('h21, O_STA,  1'b0, 'h312);
    put_ins('h24, O_DT,   1'b0, 'h0A5);
    put_ins('h27, O_BEQ,  1'b0, 'h024);
    put_ins('h2A, O_DI,   1'b0, 'h0A5);
    put_ins('h2D, O_STA,  1'b0, 'h315);
    put_ins('h30, O_DO,   1'b0, 'h0B6);
    put_word('h33, 24'hFF0000);
    put_ins('h60, O_LDA,  1'b0, 'h318);
    put_ins('h63, O_ADD,  1'b0, 'h318);
    put_ins('h66, O_RET,  1'b0, 0);
    put_word('h303, 24'h000004);
    put_word('h30F, 24'h123456);
    put_word('h318, 24'h000005);
    mem['h31B] <= 8'hAB;
    mem['h320] <= 8'h11; mem['h321] <= 8'h22; mem['h322] <= 8'h33; mem['h323] <= 8'h44;
    mem['h334] <= 8'h5A;
    run_prog(400, cyc, fa);
    @(negedge clk);
    chk("R7 loop count stored in X", get_word('h306), 24'h000004);
    chk("R3 word store big-endian low byte", mem['h308], 8'h04);
    chk("R2 indexed copy", {mem['h330], mem['h331], mem['h332], mem['h333]}, 32'h11223344);
    chk("R7 loop stops at bound", mem['h334], 8'h5A);
    chk("R6 subroutine result", get_word('h309), 24'h00000A);
    chk("R6 return address in L", get_word('h30C), 24'h000015);
    chk("R3 byte load keeps upper bits", get_word('h312), 24'h1234AB);
    chk("R8 device input into low byte", get_word('h315), 24'h1234C3);
    chk("R8 device read once at id", {drd_cnt[7:0], drd_id}, {8'd1, 8'hA5});
    chk("R8 device write id and data", {dwr_cnt[7:0], dwr_id, dwr_data}, {8'd1, 8'hB6, 8'hC3});
    chk("R8 busy poll waited for ready", (cyc > 400) ? 1'b1 : 1'b0, 1'b1);
    chk("R9 halted", halt, 1'b1);

    r0 = rd_cnt; w0 = wr_cnt;
    repeat (20) @(negedge clk);
    chk("R9 halt holds", halt, 1'b1);
    chk("R9 no access after halt", {rd_cnt - r0, wr_cnt - w0}, 64'd0);
    chk("R9 no device access after halt", dwr_cnt + drd_cnt, 2);

    do_reset(1'b1);
    summary();
    $finish;
  end

endmodule